// File: doc/BRIEF.md
# Programmable Duty-Cycle Clock Divider

This block derives a slower clock from its input clock. Separate high-time and low-time counts, each a 6-bit value in input cycles, set both the division ratio and the duty cycle. An edge option stretches each high phase by half an input period, so odd ratios reach a duty cycle close to 50%. A bypass option hands the input clock straight to the output, and an enable option forces the output low. A 6-bit start delay, counted in input cycles, sets the phase of the first high pulse after the divider is started.

Software programs the divider through a two-word write port. Word 0 holds the timing fields and mode bits, and word 1 holds the start delay. New high, low and edge values are picked up only when a high phase begins, so a change made while the divider runs never produces a truncated pulse. A synchronous clear input restarts the start delay without a reset.

Top module: `duty_clk_div`

## Requirements
- R1: While `rst_n` is low, and after reset until an enabling write, `clk_out` is low. After reset, word 0 reads as high=1, low=1, with edge, bypass and enable all clear, and word 1 holds delay 0.
- R2: When running, the output is high for H input cycles and then low for L input cycles, and this pattern repeats. H comes from word 0 bits [5:0] and L from word 0 bits [11:6].
- R3: After a start, the output stays low for D input cycles before the first high phase. D comes from word 1 bits [5:0].
- R4: A high-time or low-time field of 0 counts as 64 cycles.
- R5: When the edge bit (word 0 bit 12) is set, each high-to-low transition occurs half an input period later. The high phase lasts H+0.5 cycles and the low phase lasts L-0.5 cycles.
- R6: When the bypass bit (word 0 bit 13) and the enable bit are both set, `clk_out` follows `clk_in`.
- R7: When the enable bit (word 0 bit 14) is clear, `clk_out` is held low, whatever the other fields hold.
- R8: A new high, low or edge value written while the divider runs takes effect at the next rising output edge. Every high phase has the old length or the new one, and every high phase that begins after the write edge has the new one.
- R9: A one-cycle `sync_clr` pulse restarts the start delay. The output stays low for D cycles after the clear edge and then resumes the H/L pattern.
- R10: A write takes effect at the rising edge where `cfg_we` is sampled high. `cfg_addr` 0 selects word 0 and 1 selects word 1. After an enabling write, the delay count starts at the next rising edge, so cycle k (k>=1), counted from that edge, is high exactly when k>D and (k-D-1) mod (H+L) < H.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Write strobe for the configuration words |
| cfg_addr | input | 1 | Word select: 0 timing/mode word, 1 delay word |
| cfg_wdata | input | 16 | Write data |
| sync_clr | input | 1 | Synchronous restart of the start delay |
| clk_out | output | 1 | Divided, bypassed or gated output clock |

## Verification
The bench builds the block with its defaults: 6-bit counts and a 16-bit write word. At this width the wrap from 0 to 64 and the longest phases fit within a few hundred cycles, so random high, low and delay values, together with the occasional zero field, cover the whole count range. The bench samples the output in both halves of every input cycle, which makes the half-period edge stretch and the bypass waveform visible.

// File: rtl/duty_clk_div_pkg.sv
package duty_clk_div_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_DELAY = 2'd1,
    PH_HIGH  = 2'd2,
    PH_LOW   = 2'd3
  } phase_e;

  // word select values on the write port
  localparam logic WORD_CTL = 1'b0;
  localparam logic WORD_DLY = 1'b1;

endpackage

// File: rtl/duty_clk_div_cfg.sv
module duty_clk_div_cfg #(
  parameter int CNT_W  = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [CNT_W-1:0]  hi_o,
  output logic [CNT_W-1:0]  lo_o,
  output logic [CNT_W-1:0]  dly_o,
  output logic              edge_o,
  output logic              bypass_o,
  output logic              en_o
);
  import duty_clk_div_pkg::*;

  localparam int HI_LSB   = 0;
  localparam int LO_LSB   = CNT_W;
  localparam int EDGE_BIT = 2 * CNT_W;
  localparam int BYP_BIT  = EDGE_BIT + 1;
  localparam int EN_BIT   = EDGE_BIT + 2;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic ctl_ld, dly_ld;
  logic [CNT_W-1:0] hi_q, lo_q, dly_q, hi_d, lo_d, dly_d;
  logic edge_q, byp_q, en_q, edge_d, byp_d, en_d;
  logic unused_wbits;

  assign ctl_ld = we_i && (addr_i == WORD_CTL);
  assign dly_ld = we_i && (addr_i == WORD_DLY);

  always_comb begin
    hi_d   = wdata_i[HI_LSB +: CNT_W];
    lo_d   = wdata_i[LO_LSB +: CNT_W];
    edge_d = wdata_i[EDGE_BIT];
    byp_d  = wdata_i[BYP_BIT];
    en_d   = wdata_i[EN_BIT];
    dly_d  = wdata_i[CNT_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q   <= ONE;
      lo_q   <= ONE;
      edge_q <= 1'b0;
      byp_q  <= 1'b0;
      en_q   <= 1'b0;
    end else if (ctl_ld) begin
      hi_q   <= hi_d;
      lo_q   <= lo_d;
      edge_q <= edge_d;
      byp_q  <= byp_d;
      en_q   <= en_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dly_q <= '0;
    end else if (dly_ld) begin
      dly_q <= dly_d;
    end
  end

  generate
    if (DATA_W > EN_BIT + 1) begin : g_spare
      assign unused_wbits = ^wdata_i[DATA_W-1:EN_BIT+1];
    end else begin : g_nospare
      assign unused_wbits = 1'b0;
    end
  endgenerate

  assign hi_o     = hi_q;
  assign lo_o     = lo_q;
  assign dly_o    = dly_q;
  assign edge_o   = edge_q;
  assign bypass_o = byp_q;
  assign en_o     = en_q;

endmodule

// File: rtl/duty_clk_div_phase.sv
module duty_clk_div_phase #(
  parameter int CNT_W = 6
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     en_i,
  input  logic                     restart_i,
  input  logic [CNT_W-1:0]         hi_i,
  input  logic [CNT_W-1:0]         lo_i,
  input  logic [CNT_W-1:0]         dly_i,
  input  logic                     edge_i,
  output logic                     ph_hi_o,
  output logic                     edge_act_o,
  output logic [CNT_W-1:0]         hi_act_o,
  output logic [CNT_W-1:0]         cnt_o,
  output duty_clk_div_pkg::phase_e st_o
);
  import duty_clk_div_pkg::*;

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  phase_e st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] hact_q, lact_q;
  logic eact_q;
  logic act_ld;
  logic cnt_zero;

  assign cnt_zero = (cnt_q == '0);

  // next state; a count value v is loaded as v-1, so 0 wraps to 2^CNT_W cycles
  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    act_ld = 1'b0;
    if (!en_i) begin
      st_d  = PH_IDLE;
      cnt_d = '0;
    end else if (restart_i || (st_q == PH_IDLE)) begin
      if (dly_i == '0) begin
        st_d   = PH_HIGH;
        cnt_d  = hi_i - ONE;
        act_ld = 1'b1;
      end else begin
        st_d  = PH_DELAY;
        cnt_d = dly_i - ONE;
      end
    end else begin
      unique case (st_q)
        PH_DELAY, PH_LOW: begin
          if (cnt_zero) begin
            st_d   = PH_HIGH;
            cnt_d  = hi_i - ONE;
            act_ld = 1'b1;
          end else begin
            cnt_d = cnt_q - ONE;
          end
        end
        PH_HIGH: begin
          if (cnt_zero) begin
            st_d  = PH_LOW;
            cnt_d = lact_q - ONE;
          end else begin
            cnt_d = cnt_q - ONE;
          end
        end
        default: begin
          st_d  = PH_IDLE;
          cnt_d = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= PH_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  // active settings, captured only where a high phase begins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hact_q <= ONE;
      lact_q <= ONE;
      eact_q <= 1'b0;
    end else if (act_ld) begin
      hact_q <= hi_i;
      lact_q <= lo_i;
      eact_q <= edge_i;
    end
  end

  assign ph_hi_o    = (st_q == PH_HIGH);
  assign edge_act_o = eact_q;
  assign hi_act_o   = hact_q;
  assign cnt_o      = cnt_q;
  assign st_o       = st_q;

endmodule

// File: rtl/duty_clk_div_out.sv
module duty_clk_div_out (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ph_hi_i,
  input  logic edge_i,
  input  logic bypass_i,
  input  logic en_i,
  output logic clk_o
);
  logic ext_q, ext_d;
  logic shaped;

  assign ext_d = ph_hi_i & edge_i;

  // falling-edge register holds the high level for one extra half period
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ext_q <= 1'b0;
    end else begin
      ext_q <= ext_d;
    end
  end

  assign shaped = ph_hi_i | ext_q;
  assign clk_o  = en_i & (bypass_i ? clk_i : shaped);

endmodule

// File: rtl/duty_clk_div.sv
module duty_clk_div #(
  parameter int CNT_W  = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk_in,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              sync_clr,
  output logic              clk_out
);
  import duty_clk_div_pkg::*;

  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_pipe_q;
  logic rst_sync_n;

  logic [CNT_W-1:0] cfg_hi, cfg_lo, cfg_dly, hi_act, cnt_val;
  logic cfg_edge, cfg_byp, cfg_en;
  logic ph_hi, edge_act;
  phase_e ph_st;

  // reset asserts at once and is released after SYNC_STAGES edges
  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= {rst_pipe_q[SYNC_STAGES-2:0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe_q[SYNC_STAGES-1];

  duty_clk_div_cfg #(.CNT_W(CNT_W), .DATA_W(DATA_W)) i_cfg (
    .clk_i    (clk_in),
    .rst_ni   (rst_sync_n),
    .we_i     (cfg_we),
    .addr_i   (cfg_addr),
    .wdata_i  (cfg_wdata),
    .hi_o     (cfg_hi),
    .lo_o     (cfg_lo),
    .dly_o    (cfg_dly),
    .edge_o   (cfg_edge),
    .bypass_o (cfg_byp),
    .en_o     (cfg_en)
  );

  duty_clk_div_phase #(.CNT_W(CNT_W)) i_phase (
    .clk_i      (clk_in),
    .rst_ni     (rst_sync_n),
    .en_i       (cfg_en),
    .restart_i  (sync_clr),
    .hi_i       (cfg_hi),
    .lo_i       (cfg_lo),
    .dly_i      (cfg_dly),
    .edge_i     (cfg_edge),
    .ph_hi_o    (ph_hi),
    .edge_act_o (edge_act),
    .hi_act_o   (hi_act),
    .cnt_o      (cnt_val),
    .st_o       (ph_st)
  );

  duty_clk_div_out i_out (
    .clk_i    (clk_in),
    .rst_ni   (rst_sync_n),
    .ph_hi_i  (ph_hi),
    .edge_i   (edge_act),
    .bypass_i (cfg_byp),
    .en_i     (cfg_en),
    .clk_o    (clk_out)
  );

endmodule

// File: rtl/duty_clk_div_chk.sv
module duty_clk_div_chk #(
  parameter int CNT_W = 6
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     en_i,
  input logic                     restart_i,
  input logic                     ph_hi_i,
  input logic [CNT_W-1:0]         dly_i,
  input logic [CNT_W-1:0]         hact_i,
  input logic [CNT_W-1:0]         cnt_i,
  input duty_clk_div_pkg::phase_e st_i
);
  import duty_clk_div_pkg::*;

  // R7
  disabled_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !ph_hi_i && st_i == PH_IDLE);

  // R9
  restart_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i && en_i && dly_i != '0 |=> !ph_hi_i && st_i == PH_DELAY);

  // R8
  hold_setting_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ph_hi_i && $past(ph_hi_i) |-> $stable(hact_i));

  // R2
  rise_on_expiry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ph_hi_i) |-> $past(cnt_i) == '0 || $past(st_i) == PH_IDLE || $past(restart_i));

  // R2
  fall_on_expiry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ph_hi_i) && $past(en_i) && !$past(restart_i) |-> $past(cnt_i) == '0);

endmodule

bind duty_clk_div duty_clk_div_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_in),
  .rst_ni    (rst_sync_n),
  .en_i      (cfg_en),
  .restart_i (sync_clr),
  .ph_hi_i   (ph_hi),
  .dly_i     (cfg_dly),
  .hact_i    (hi_act),
  .cnt_i     (cnt_val),
  .st_i      (ph_st)
);

// File: tb/test_duty_clk_div.sv
`timescale 1ns/1ps
module test_duty_clk_div;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic        cfg_addr;
  logic [15:0] cfg_wdata;
  logic        sync_clr;
  logic        clk_out;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  duty_clk_div i_duty_clk_div (
    .clk_in    (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .sync_clr  (sync_clr),
    .clk_out   (clk_out)
  );

  function automatic logic [15:0] ctl_word(int h, int l, bit e, bit b, bit en);
    return {1'b0, en, b, e, 6'(l), 6'(h)};
  endfunction

  function automatic int eff(int v);
    return (v == 0) ? 64 : v;
  endfunction

  // expected level in cycle k after the start edge; half 0 = clock-high half
  function automatic logic exp_level(int k, int half, int d, int h, int l, bit e);
    int p;
    if (k <= d) return 1'b0;
    p = (k - d - 1) % (h + l);
    if (p < h) return 1'b1;
    if (e && p == h && half == 0) return 1'b1;
    return 1'b0;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // all tasks start and end 1 ns after a rising edge
  task automatic write_word(bit a, logic [15:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic observe(int d, int h, int l, bit e, int ncyc, string req);
    int bad_k = -1, bad_a = 0, bad_e = 0;
    for (int k = 1; k <= ncyc; k++) begin
      for (int half = 0; half < 2; half++) begin
        logic ex;
        ex = exp_level(k, half, d, h, l, e);
        if (clk_out !== ex && bad_k < 0) begin
          bad_k = k; bad_a = int'(clk_out); bad_e = int'(ex);
        end
        if (half == 0) #2;
      end
      @(posedge clk); #1;
    end
    if (bad_k >= 0) $display("  mismatch at cycle %0d (d=%0d h=%0d l=%0d e=%0d)", bad_k, d, h, l, e);
    check(bad_k < 0, req, bad_a, bad_e);
  endtask

  task automatic run_cfg(int d, int h, int l, bit e, string req);
    write_word(1'b0, ctl_word(h, l, e, 1'b0, 1'b0));
    @(posedge clk); #1;
    write_word(1'b1, 16'(d));
    write_word(1'b0, ctl_word(h, l, e, 1'b0, 1'b1));
    // R10: nothing starts on the write edge itself
    check(clk_out == 1'b0, "R10 start edge", int'(clk_out), 0);
    @(posedge clk); #1;
    observe(d, eff(h), eff(l), e, d + 2 * (eff(h) + eff(l)) + 2, req);
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int unsigned seed_dummy;
    int run_len, run_start, bad, new_seen;
    logic prev;
    seed_dummy = $urandom(32'd20251);
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = 1'b0; cfg_wdata = '0; sync_clr = 1'b0;

    // R1: low during and after reset
    repeat (3) @(posedge clk);
    #1;
    check(clk_out == 1'b0, "R1 in reset", int'(clk_out), 0);
    rst_n = 1'b1;
    bad = 0;
    repeat (6) begin
      @(posedge clk); #1;
      if (clk_out !== 1'b0) bad++;
      #2;
      if (clk_out !== 1'b0) bad++;
    end
    check(bad == 0, "R1 after reset", bad, 0);

    // R2 R3 R10 directed basics
    run_cfg(0, 2, 3, 1'b0, "R2 R10 h2 l3");
    run_cfg(4, 1, 1, 1'b0, "R3 d4 h1 l1");
    run_cfg(63, 3, 2, 1'b0, "R3 d63");
    // R4 zero counts as 64
    run_cfg(1, 0, 1, 1'b0, "R4 high 64");
    run_cfg(0, 2, 0, 1'b0, "R4 low 64");
    // R5 half-period stretch, odd ratio
    run_cfg(2, 1, 2, 1'b1, "R5 edge h1 l2");
    run_cfg(0, 4, 1, 1'b1, "R5 edge h4 l1");

    // random mix: R2 R3 R4 R5
    for (int i = 0; i < 24; i++) begin
      int h, l, d;
      bit e;
      h = ($urandom_range(0, 11) == 0) ? 0 : int'($urandom_range(1, 9));
      l = ($urandom_range(0, 11) == 0) ? 0 : int'($urandom_range(1, 9));
      d = int'($urandom_range(0, 12));
      e = 1'($urandom_range(0, 1));
      run_cfg(d, h, l, e, "R2 R3 R4 R5 random");
    end

    // R6 bypass follows input
    write_word(1'b0, ctl_word(3, 3, 1'b0, 1'b1, 1'b1));
    bad = 0;
    repeat (8) begin
      @(posedge clk); #1;
      if (clk_out !== 1'b1) bad++;
      #2;
      if (clk_out !== 1'b0) bad++;
    end
    check(bad == 0, "R6 bypass", bad, 0);

    // R7 disabled: low even with bypass set, and when stopping a running divider
    write_word(1'b0, ctl_word(3, 3, 1'b0, 1'b1, 1'b0));
    bad = 0;
    repeat (8) begin
      #0; if (clk_out !== 1'b0) bad++;
      #2; if (clk_out !== 1'b0) bad++;
      @(posedge clk); #1;
    end
    check(bad == 0, "R7 disabled bypass", bad, 0);
    write_word(1'b1, 16'd0);
    write_word(1'b0, ctl_word(1, 1, 1'b1, 1'b0, 1'b1));
    repeat (5) begin @(posedge clk); #1; end
    write_word(1'b0, ctl_word(1, 1, 1'b1, 1'b0, 1'b0));
    bad = 0;
    repeat (10) begin
      if (clk_out !== 1'b0) bad++;
      #2; if (clk_out !== 1'b0) bad++;
      @(posedge clk); #1;
    end
    check(bad == 0, "R7 disable while running", bad, 0);

    // R9 restart with a new delay while running
    write_word(1'b0, ctl_word(2, 2, 1'b0, 1'b0, 1'b1));
    repeat (7) begin @(posedge clk); #1; end
    write_word(1'b1, 16'd5);
    repeat (2) begin @(posedge clk); #1; end
    sync_clr = 1'b1;
    @(posedge clk); #1;
    sync_clr = 1'b0;
    observe(5, 2, 2, 1'b0, 20, "R9 restart");

    // R8 change high time while running
    write_word(1'b0, ctl_word(3, 3, 1'b0, 1'b0, 1'b0));
    write_word(1'b1, 16'd0);
    write_word(1'b0, ctl_word(3, 3, 1'b0, 1'b0, 1'b1));
    repeat (8) begin @(posedge clk); #1; end
    write_word(1'b0, ctl_word(6, 3, 1'b0, 1'b0, 1'b1));
    prev = clk_out; run_start = 0; run_len = prev ? 1 : 0;
    bad = 0; new_seen = 0;
    for (int j = 1; j <= 40; j++) begin
      @(posedge clk); #1;
      if (clk_out && !prev) begin run_start = j; run_len = 1; end
      else if (clk_out) run_len++;
      else if (prev) begin
        if (run_start >= 1) begin
          new_seen++;
          if (run_len != 6) bad++;
        end else if (run_len > 3 || run_len < 1) bad++;
      end
      prev = clk_out;
    end
    check(bad == 0, "R8 run lengths", bad, 0);
    check(new_seen >= 3, "R8 new value applied", new_seen, 3);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule